// File: doc/BRIEF.md
# Boot ROM/RAM Overlay Decoder

This block produces the three active-low memory chip selects for an 8-bit processor with a 64 KB address space. The top half of the space (address bit 15 high) always reaches the upper RAM bank. The bottom half can reach either the boot ROM or the lower RAM bank, and one overlay flag decides which.

Reset clears the flag. With the flag clear, the first instruction fetch at address 0 lands in ROM. Boot firmware copies itself into the upper RAM and jumps there. It then writes a 1 to a dedicated I/O port. From then on the bottom half is RAM too, which gives a full 64 KB of RAM.

The flag is kept as a two-state machine:
- `ST_BOOT`: flag clear, bottom half goes to ROM.
- `ST_RUN`: flag set, bottom half goes to lower RAM.

It has two transitions:
- `go_run`: `ST_BOOT` to `ST_RUN`, taken on a port write with data 1.
- `go_boot`: `ST_RUN` to `ST_BOOT`, taken on a port write with data 0, or at once on reset.

Top module: `boot_overlay_decoder`

## Requirements
- R1: When `mreq_n` is low, `iorq_n` is high and `a15` is 1, `hram_cs_n` is low whatever the flag state.
- R2: After reset `flag_q` is 0. A memory request with `a15` = 0 then drives `rom_cs_n` low and `lram_cs_n` high.
- R3: A port write latches `flag_din` = 1 on the next rising clock edge, and `flag_q` reads 1. A port write is `iorq_n` = 0, `wr_n` = 0 and `io_addr[7:0]` = 0x00 during one rising edge. After that edge, memory requests with `a15` = 0 drive `lram_cs_n` low and `rom_cs_n` high.
- R4: A port write with `flag_din` = 0 clears the flag on the next rising edge, and bottom-half requests return to ROM.
- R5: While `mreq_n` is high, all three selects are high.
- R6: While `iorq_n` is low, all three selects are high.
- R7: At most one of the three selects is low at any time.
- R8: The flag keeps its value in each of these cases:
  - an I/O write to any port address other than 0x00;
  - an I/O cycle with `wr_n` high;
  - a memory write (`mreq_n` low) with `io_addr` = 0x00.
- R9: `flag_q` is 1 exactly when the machine is in `ST_RUN`. It updates only on the clock edge that samples a port write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a15 | input | 1 | Address bit 15 (half select) |
| io_addr | input | 8 | Low address bits used as I/O port number |
| flag_din | input | 1 | Data bit 0 of the bus |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| wr_n | input | 1 | Write strobe, active low |
| rom_cs_n | output | 1 | Boot ROM select, active low |
| lram_cs_n | output | 1 | Lower RAM select, active low |
| hram_cs_n | output | 1 | Upper RAM select, active low |
| flag_q | output | 1 | Overlay flag state |

## Verification
The assertions assume that `mreq_n` and `iorq_n` are never low in the same cycle, as the processor never issues both requests at once. They also assume a port write stays stable across the sampling clock edge. The stimulus respects both assumptions: it drives all inputs half a cycle before the edge, and it picks each cycle's bus activity from memory, I/O or idle, never two at once. Port writes at address 0x00 are biased so that the flag toggles often. Writes to other ports, I/O reads and memory writes with a zero low address are mixed in as near misses.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
    typedef enum logic {
        ST_BOOT = 1'b0,
        ST_RUN  = 1'b1
    } ovl_state_e;
endpackage

// File: rtl/ovl_port_decode.sv
module ovl_port_decode #(
    parameter int          IO_AW     = 8,
    parameter logic [7:0]  FLAG_PORT = 8'h00
) (
    input  logic             iorq_n,
    input  logic             wr_n,
    input  logic [IO_AW-1:0] io_addr,
    output logic             port_wr
);
    localparam logic [IO_AW-1:0] PORT_MATCH = IO_AW'(FLAG_PORT);

    always_comb begin
        port_wr = !iorq_n && !wr_n && (io_addr == PORT_MATCH);
    end
endmodule

// File: rtl/ovl_flag_fsm.sv
module ovl_flag_fsm
    import ovl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic port_wr,
    input  logic flag_din,
    output logic overlay_on
);
    ovl_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT: if (port_wr && flag_din)  state_d = ST_RUN;   // go_run
            ST_RUN:  if (port_wr && !flag_din) state_d = ST_BOOT;  // go_boot
            default: state_d = ST_BOOT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    always_comb begin
        overlay_on = (state_q == ST_RUN);
    end

    // R3
    set_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr && flag_din |=> overlay_on);
    // R4
    clr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr && !flag_din |=> !overlay_on);
    // R8
    hold_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_wr |=> $stable(overlay_on));
endmodule

// File: rtl/ovl_select.sv
module ovl_select (
    input  logic clk,
    input  logic rst_n,
    input  logic a15,
    input  logic mreq_n,
    input  logic iorq_n,
    input  logic overlay_on,
    output logic rom_cs_n,
    output logic lram_cs_n,
    output logic hram_cs_n
);
    logic mem_cyc;

    always_comb begin
        mem_cyc   = !mreq_n && iorq_n;
        rom_cs_n  = !(mem_cyc && !a15 && !overlay_on);
        lram_cs_n = !(mem_cyc && !a15 &&  overlay_on);
        hram_cs_n = !(mem_cyc &&  a15);
    end

    // R1
    upper_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mreq_n && iorq_n && a15 |-> !hram_cs_n);
    // R5
    no_mreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_n |-> (rom_cs_n && lram_cs_n && hram_cs_n));
    // R6
    no_io_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !iorq_n |-> (rom_cs_n && lram_cs_n && hram_cs_n));
    // R7
    one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!rom_cs_n, !lram_cs_n, !hram_cs_n}));
endmodule

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder #(
    parameter int         IO_AW     = 8,
    parameter logic [7:0] FLAG_PORT = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a15,
    input  logic [IO_AW-1:0] io_addr,
    input  logic             flag_din,
    input  logic             mreq_n,
    input  logic             iorq_n,
    input  logic             wr_n,
    output logic             rom_cs_n,
    output logic             lram_cs_n,
    output logic             hram_cs_n,
    output logic             flag_q
);
    logic port_wr;
    logic overlay_on;

    ovl_port_decode #(.IO_AW(IO_AW), .FLAG_PORT(FLAG_PORT)) i_dec (
        .iorq_n  (iorq_n),
        .wr_n    (wr_n),
        .io_addr (io_addr),
        .port_wr (port_wr)
    );

    ovl_flag_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .port_wr    (port_wr),
        .flag_din   (flag_din),
        .overlay_on (overlay_on)
    );

    ovl_select i_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .a15        (a15),
        .mreq_n     (mreq_n),
        .iorq_n     (iorq_n),
        .overlay_on (overlay_on),
        .rom_cs_n   (rom_cs_n),
        .lram_cs_n  (lram_cs_n),
        .hram_cs_n  (hram_cs_n)
    );

    always_comb flag_q = overlay_on;

    // R9
    flag_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flag_q) |-> $past(port_wr));
endmodule

// File: tb/test_boot_overlay_decoder.sv
module test_boot_overlay_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       a15 = 1'b0;
    logic [7:0] io_addr = 8'h00;
    logic       flag_din = 1'b0;
    logic       mreq_n = 1'b1;
    logic       iorq_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       rom_cs_n, lram_cs_n, hram_cs_n, flag_q;

    int checks = 0;
    int failures = 0;
    bit model_flag = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    boot_overlay_decoder i_boot_overlay_decoder (
        .clk(clk), .rst_n(rst_n), .a15(a15), .io_addr(io_addr),
        .flag_din(flag_din), .mreq_n(mreq_n), .iorq_n(iorq_n), .wr_n(wr_n),
        .rom_cs_n(rom_cs_n), .lram_cs_n(lram_cs_n), .hram_cs_n(hram_cs_n),
        .flag_q(flag_q)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act={rom,lram,hram,flag}=%b exp=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: compare every output against behaviour.
    task automatic compare();
        logic r, l, h;
        string req;
        bit mem;
        mem = !mreq_n && iorq_n;
        r = !(mem && !a15 && !model_flag);
        l = !(mem && !a15 && model_flag);
        h = !(mem && a15);
        if (!iorq_n)         req = "R6";
        else if (mreq_n)     req = "R5";
        else if (a15)        req = "R1";
        else if (model_flag) req = "R3";
        else                 req = "R2";
        chk(req, {rom_cs_n, lram_cs_n, hram_cs_n, flag_q}, {r, l, h, model_flag});
        chk("R7", {1'b0, 3'(((!rom_cs_n) + (!lram_cs_n) + (!hram_cs_n)) > 1)}, 4'b0000);
        chk("R9", {3'b000, flag_q}, {3'b000, model_flag});
    endtask

    // Apply one bus cycle: drive at negedge, compare, model updates at posedge.
    task automatic bus(input bit m, input bit io, input bit w, input bit hi,
                       input logic [7:0] pa, input bit d);
        @(negedge clk);
        mreq_n = !m; iorq_n = !io; wr_n = !w; a15 = hi; io_addr = pa; flag_din = d;
        #2;
        compare();
        @(posedge clk);
        if (io && w && pa == 8'h00) model_flag = d;
    endtask

    task automatic idle();
        bus(0, 0, 0, 0, 8'h00, 0);
    endtask

    initial begin
        #100000000;
        failures++;
        $display("FAIL watchdog act=hung exp=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R2: reset state
        chk("R2", {rom_cs_n, lram_cs_n, hram_cs_n, flag_q}, 4'b1110);
        @(negedge clk); rst_n = 1'b1;
        bus(1, 0, 0, 0, 8'h00, 0);       // R2 fetch at 0 -> ROM
        bus(1, 0, 0, 1, 8'h00, 0);       // R1 upper
        // R8 near misses
        bus(0, 1, 1, 0, 8'h01, 1);       // other port
        bus(0, 1, 0, 0, 8'h00, 1);       // I/O read
        bus(1, 0, 1, 0, 8'h00, 1);       // memory write
        bus(1, 0, 0, 0, 8'h00, 0);
        chk("R8", {3'b000, flag_q}, 4'b0000);
        // R3 set flag
        bus(0, 1, 1, 0, 8'h00, 1);
        bus(1, 0, 0, 0, 8'h00, 0);
        chk("R3", {rom_cs_n, lram_cs_n, hram_cs_n, flag_q}, 4'b1011);
        bus(1, 0, 0, 1, 8'h00, 0);       // R1 with flag set
        bus(0, 1, 1, 0, 8'h80, 0);       // R8 other port, flag stays
        bus(1, 0, 0, 0, 8'h00, 0);
        chk("R8", {3'b000, flag_q}, 4'b0001);
        // R4 clear flag
        bus(0, 1, 1, 0, 8'h00, 0);
        bus(1, 0, 0, 0, 8'h00, 0);
        chk("R4", {rom_cs_n, lram_cs_n, hram_cs_n, flag_q}, 4'b0110);
        // Set, then reset clears it (R2)
        bus(0, 1, 1, 0, 8'h00, 1);
        idle();
        @(negedge clk); rst_n = 1'b0; model_flag = 1'b0;
        #2;
        chk("R2", {3'b000, flag_q}, 4'b0000);
        @(negedge clk); rst_n = 1'b1;
        // Random traffic against the model
        for (int i = 0; i < 2000; i++) begin
            int kind;
            kind = int'($urandom_range(0, 5));
            case (kind)
                0, 1: bus(1, 0, 1'($urandom), 1'($urandom), 8'($urandom), 1'($urandom));
                2:    bus(0, 1, 1, 0, 8'h00, 1'($urandom));
                3:    bus(0, 1, 1'($urandom), 1'($urandom), 8'($urandom_range(0, 3)), 1'($urandom));
                default: bus(0, 0, 1'($urandom), 1'($urandom), 8'($urandom), 1'($urandom));
            endcase
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule